// File: doc/BRIEF.md
# Paired Ring Queue Doorbell Tracker

This block keeps the producer and consumer indices of a small set of ring queues that a host and a storage device share. Every queue number names both a submission ring and a completion ring. The host owns two indices and moves them through per-queue doorbell writes: the submission tail, after it has placed new commands, and the completion head, after it has consumed results. The device side owns the other two. A command engine advances a submission head each time it takes a command. A completion poster advances the tail of the completion ring that the submission ring was bound to when it was configured.

The block holds no entry contents. It turns ring indices into slot byte offsets. A submission slot is 64 bytes and a completion slot is 16 bytes, and each ring starts at a configured base slot. It reports per-ring occupancy to the command engine and refuses completions when the target ring has no room. Each accepted completion gives a one-cycle event that carries the completion ring number, the slot offset and the identity of the command it answers. A configuration write models queue creation. It sets a ring's size, its base slot and, for a submission ring, its completion binding.

Top module: `qdb_tracker`

## Requirements
- R1: After reset every ring is unconfigured with both indices at 0. `sq_pending`, `sq_full` and `cq_full` are all 0, `cq_empty` is all 1, and `err_flag`, `fetch_ack`, `evt_valid` and `post_stall` are 0.
- R2: A configuration write is accepted only when the size lies between 2 and 2^IDX_W inclusive. An accepted write sets size and base and clears both indices of that ring. A refused write changes nothing and sets `err_flag`.
- R3: A submission doorbell with an index below the ring size sets the tail, visible the next cycle. `sq_pending[q]` is 1 when head differs from tail. `sq_full[q]` is 1 when (tail+1) mod size equals head, so a ring of size N holds at most N-1 commands.
- R4: A doorbell whose index is not below the configured size of the addressed ring is ignored, with the ring's indices unchanged. It sets `err_flag`, which stays 1 until reset.
- R5: A fetch request for a pending submission ring gives `fetch_ack`=1 in the next cycle, with `fetch_addr` = (base+head)*64. The head then advances, wrapping from size-1 to 0. A fetch for a ring with nothing pending gives `fetch_ack`=0 and changes nothing.
- R6: An accepted post goes to the completion ring bound to `post_sqid`. The next cycle shows a one-cycle `evt_valid` with `evt_cqid`, `evt_addr` = (base+tail)*16, `evt_sqid` and `evt_sqe` echoed. The completion tail then advances, wrapping at the ring size.
- R7: A post to a completion ring that is full, meaning (tail+1) mod size equals head, or that is unconfigured is refused. The next cycle shows `post_stall`=1 and no event, and the tail is unchanged. `cq_full[q]` shows the full state.
- R8: A completion doorbell sets the completion head, which frees room. `cq_empty[q]` is 1 when head equals tail.
- R9: Submission ring 0 is always bound to completion ring 0, whatever binding value is written. A configuration of any other submission ring that asks for binding to completion ring 0 is refused as in R2.
- R10: Reconfiguring a ring drops whatever it held: both of its indices return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cq | input | 1 | 1 selects a completion ring, 0 a submission ring |
| cfg_qid | input | QW | Queue number being configured |
| cfg_size | input | IDX_W+1 | Ring size in entries |
| cfg_base | input | BASE_W | First slot of the ring |
| cfg_bind | input | QW | Completion ring bound to a submission ring |
| db_we | input | 1 | Doorbell write strobe |
| db_cq | input | 1 | 1 writes the completion head, 0 the submission tail |
| db_qid | input | QW | Queue number of the doorbell |
| db_idx | input | IDX_W | New index |
| fetch_req | input | 1 | Command engine asks to take one command |
| fetch_qid | input | QW | Submission ring to take from |
| fetch_ack | output | 1 | Fetch granted (registered) |
| fetch_addr | output | BASE_W+7 | Byte offset of the fetched submission slot |
| post_req | input | 1 | Post one completion |
| post_sqid | input | QW | Submission ring the command came from |
| post_sqe | input | IDX_W | Submission slot index of the command |
| post_stall | output | 1 | Post refused, completion ring full or unconfigured |
| evt_valid | output | 1 | One-cycle completion event |
| evt_cqid | output | QW | Completion ring written |
| evt_addr | output | BASE_W+5 | Byte offset of the completion slot written |
| evt_sqid | output | QW | Echoed submission ring number |
| evt_sqe | output | IDX_W | Echoed submission slot index |
| sq_pending | output | NQ | Per-ring: commands waiting |
| sq_full | output | NQ | Per-ring: submission ring full |
| cq_full | output | NQ | Per-ring: completion ring full |
| cq_empty | output | NQ | Per-ring: completion ring empty |
| err_flag | output | 1 | Sticky error for a refused doorbell or configuration |

## Verification
A corrupted head or tail index shows at the ports in the next cycle. It appears as a wrong `sq_pending`, `sq_full`, `cq_full` or `cq_empty` bit, or as a slot offset in `fetch_addr` or `evt_addr` that breaks the base-plus-index-times-entry-size rule on the following grant. A wrong completion binding shows up as an `evt_cqid` other than the bound ring on the first post. A wrap error stays hidden until a ring has been walked all the way round, so the stimulus takes rings past their last slot for both submission and completion traffic. An out-of-range doorbell that is wrongly taken is caught through later fetch grants and refusals, because it changes how many commands can be taken.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int SQE_SHIFT = 6;  // 64-byte submission slot
  localparam int CQE_SHIFT = 4;  // 16-byte completion slot

  typedef enum logic [0:0] {
    SIDE_SUBMIT   = 1'b0,
    SIDE_COMPLETE = 1'b1
  } ring_side_e;
endpackage

// File: rtl/qdb_ring.sv
module qdb_ring #(
  parameter int IDX_W         = 4,
  parameter int BASE_W        = 8,
  parameter bit HOST_PRODUCES = 1'b1,
  localparam int SIZE_W       = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic              dev_adv,
  output logic [BASE_W-1:0] base_q,
  output logic [IDX_W-1:0]  dev_ptr,
  output logic              eq,
  output logic              full,
  output logic              live
);
  logic [SIZE_W-1:0] size_q;
  logic [IDX_W-1:0]  host_ptr;
  logic [IDX_W-1:0]  dev_next;
  logic              host_ok;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p,
                                                input logic [SIZE_W-1:0] n);
    if ({1'b0, p} == n - SIZE_W'(1)) return '0;
    else                             return p + IDX_W'(1);
  endfunction

  assign host_ok  = ({1'b0, host_idx} < size_q);
  assign dev_next = wrap_inc(dev_ptr, size_q);
  assign eq       = (host_ptr == dev_ptr);
  assign live     = (size_q != '0);

  generate
    if (HOST_PRODUCES) begin : g_host_prod
      assign full = (wrap_inc(host_ptr, size_q) == dev_ptr);
    end else begin : g_dev_prod
      assign full = (dev_next == host_ptr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q   <= '0;
      base_q   <= '0;
      host_ptr <= '0;
      dev_ptr  <= '0;
    end else if (cfg_we) begin
      size_q   <= cfg_size;
      base_q   <= cfg_base;
      host_ptr <= '0;
      dev_ptr  <= '0;
    end else begin
      if (host_we && host_ok) host_ptr <= host_idx;
      if (dev_adv)            dev_ptr  <= dev_next;
    end
  end
endmodule

// File: rtl/qdb_fetch.sv
module qdb_fetch
  import qdb_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int IDX_W  = 4,
  parameter int BASE_W = 8,
  localparam int QW    = $clog2(NQ),
  localparam int SLOT_W = BASE_W + 1,
  localparam int FA_W  = SLOT_W + SQE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [QW-1:0]     fetch_qid,
  input  logic [NQ-1:0]     sq_pending,
  input  logic [NQ-1:0]     sq_live,
  input  logic [IDX_W-1:0]  sq_head [NQ],
  input  logic [BASE_W-1:0] sq_base [NQ],
  output logic              fetch_go,
  output logic              fetch_ack,
  output logic [FA_W-1:0]   fetch_addr
);
  logic [SLOT_W-1:0] slot;

  assign fetch_go = fetch_req && sq_pending[fetch_qid] && sq_live[fetch_qid];
  assign slot     = SLOT_W'(sq_base[fetch_qid]) + SLOT_W'(sq_head[fetch_qid]);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_ack  <= 1'b0;
      fetch_addr <= '0;
    end else begin
      fetch_ack <= fetch_go;
      if (fetch_go) fetch_addr <= {slot, {SQE_SHIFT{1'b0}}};
    end
  end
endmodule

// File: rtl/qdb_post.sv
module qdb_post
  import qdb_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int IDX_W  = 4,
  parameter int BASE_W = 8,
  localparam int QW    = $clog2(NQ),
  localparam int SLOT_W = BASE_W + 1,
  localparam int CA_W  = SLOT_W + CQE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_req,
  input  logic [QW-1:0]     post_sqid,
  input  logic [IDX_W-1:0]  post_sqe,
  input  logic [QW-1:0]     bind_tbl [NQ],
  input  logic [NQ-1:0]     cq_full,
  input  logic [NQ-1:0]     cq_live,
  input  logic [IDX_W-1:0]  cq_tail [NQ],
  input  logic [BASE_W-1:0] cq_base [NQ],
  output logic              post_go,
  output logic [QW-1:0]     post_cq,
  output logic              post_stall,
  output logic              evt_valid,
  output logic [QW-1:0]     evt_cqid,
  output logic [CA_W-1:0]   evt_addr,
  output logic [QW-1:0]     evt_sqid,
  output logic [IDX_W-1:0]  evt_sqe
);
  logic              room;
  logic [SLOT_W-1:0] slot;

  assign post_cq = bind_tbl[post_sqid];
  assign room    = cq_live[post_cq] && !cq_full[post_cq];
  assign post_go = post_req && room;
  assign slot    = SLOT_W'(cq_base[post_cq]) + SLOT_W'(cq_tail[post_cq]);

  always_ff @(posedge clk) begin
    if (rst) begin
      post_stall <= 1'b0;
      evt_valid  <= 1'b0;
      evt_cqid   <= '0;
      evt_addr   <= '0;
      evt_sqid   <= '0;
      evt_sqe    <= '0;
    end else begin
      post_stall <= post_req && !room;
      evt_valid  <= post_go;
      if (post_go) begin
        evt_cqid <= post_cq;
        evt_addr <= {slot, {CQE_SHIFT{1'b0}}};
        evt_sqid <= post_sqid;
        evt_sqe  <= post_sqe;
      end
    end
  end
endmodule

// File: rtl/qdb_tracker.sv
module qdb_tracker
  import qdb_pkg::*;
#(
  parameter int NQ      = 4,
  parameter int IDX_W   = 4,
  parameter int BASE_W  = 8,
  localparam int QW     = $clog2(NQ),
  localparam int SIZE_W = IDX_W + 1,
  localparam int SLOT_W = BASE_W + 1,
  localparam int FA_W   = SLOT_W + SQE_SHIFT,
  localparam int CA_W   = SLOT_W + CQE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_cq,
  input  logic [QW-1:0]     cfg_qid,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [QW-1:0]     cfg_bind,
  input  logic              db_we,
  input  logic              db_cq,
  input  logic [QW-1:0]     db_qid,
  input  logic [IDX_W-1:0]  db_idx,
  input  logic              fetch_req,
  input  logic [QW-1:0]     fetch_qid,
  output logic              fetch_ack,
  output logic [FA_W-1:0]   fetch_addr,
  input  logic              post_req,
  input  logic [QW-1:0]     post_sqid,
  input  logic [IDX_W-1:0]  post_sqe,
  output logic              post_stall,
  output logic              evt_valid,
  output logic [QW-1:0]     evt_cqid,
  output logic [CA_W-1:0]   evt_addr,
  output logic [QW-1:0]     evt_sqid,
  output logic [IDX_W-1:0]  evt_sqe,
  output logic [NQ-1:0]     sq_pending,
  output logic [NQ-1:0]     sq_full,
  output logic [NQ-1:0]     cq_full,
  output logic [NQ-1:0]     cq_empty,
  output logic              err_flag
);
  localparam logic [SIZE_W-1:0] MAX_SIZE = SIZE_W'(1) << IDX_W;

  logic [IDX_W-1:0]  sq_head [NQ];
  logic [BASE_W-1:0] sq_base [NQ];
  logic [IDX_W-1:0]  cq_tail [NQ];
  logic [BASE_W-1:0] cq_base [NQ];
  logic [QW-1:0]     bind_tbl [NQ];
  logic [NQ-1:0]     sq_eq, sq_live, cq_live;
  logic              fetch_go, post_go;
  logic [QW-1:0]     post_cq;
  logic              size_ok, bind_ok, cfg_ok;
  logic [SIZE_W-1:0] db_size;
  logic [SIZE_W-1:0] sq_size [NQ];
  logic [SIZE_W-1:0] cq_size [NQ];
  logic              db_ok;

  // Configuration acceptance: size range and admin-pair isolation
  assign size_ok = (cfg_size >= SIZE_W'(2)) && (cfg_size <= MAX_SIZE);
  assign bind_ok = (cfg_cq == SIDE_COMPLETE) || (cfg_qid == '0) || (cfg_bind != '0);
  assign cfg_ok  = size_ok && bind_ok;

  // Shadow of the ring sizes for the doorbell range check
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) begin
        sq_size[i]  <= '0;
        cq_size[i]  <= '0;
        bind_tbl[i] <= '0;
      end
    end else if (cfg_we && cfg_ok) begin
      if (cfg_cq == SIDE_COMPLETE) begin
        cq_size[cfg_qid] <= cfg_size;
      end else begin
        sq_size[cfg_qid]  <= cfg_size;
        bind_tbl[cfg_qid] <= (cfg_qid == '0) ? '0 : cfg_bind;
      end
    end
  end

  assign db_size = (db_cq == SIDE_COMPLETE) ? cq_size[db_qid] : sq_size[db_qid];
  assign db_ok   = ({1'b0, db_idx} < db_size);

  always_ff @(posedge clk) begin
    if (rst)                              err_flag <= 1'b0;
    else if ((db_we && !db_ok) || (cfg_we && !cfg_ok)) err_flag <= 1'b1;
  end

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_pair
      logic sq_cfg, cq_cfg, sq_db, cq_db, sq_adv, cq_adv;

      assign sq_cfg = cfg_we && cfg_ok && (cfg_cq == SIDE_SUBMIT)   && (cfg_qid == QW'(q));
      assign cq_cfg = cfg_we && cfg_ok && (cfg_cq == SIDE_COMPLETE) && (cfg_qid == QW'(q));
      assign sq_db  = db_we && (db_cq == SIDE_SUBMIT)   && (db_qid == QW'(q));
      assign cq_db  = db_we && (db_cq == SIDE_COMPLETE) && (db_qid == QW'(q));
      assign sq_adv = fetch_go && (fetch_qid == QW'(q));
      assign cq_adv = post_go  && (post_cq   == QW'(q));

      qdb_ring #(.IDX_W(IDX_W), .BASE_W(BASE_W), .HOST_PRODUCES(1'b1)) u_sq (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (sq_cfg),
        .cfg_size (cfg_size),
        .cfg_base (cfg_base),
        .host_we  (sq_db),
        .host_idx (db_idx),
        .dev_adv  (sq_adv),
        .base_q   (sq_base[q]),
        .dev_ptr  (sq_head[q]),
        .eq       (sq_eq[q]),
        .full     (sq_full[q]),
        .live     (sq_live[q])
      );

      qdb_ring #(.IDX_W(IDX_W), .BASE_W(BASE_W), .HOST_PRODUCES(1'b0)) u_cq (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cq_cfg),
        .cfg_size (cfg_size),
        .cfg_base (cfg_base),
        .host_we  (cq_db),
        .host_idx (db_idx),
        .dev_adv  (cq_adv),
        .base_q   (cq_base[q]),
        .dev_ptr  (cq_tail[q]),
        .eq       (cq_empty[q]),
        .full     (cq_full[q]),
        .live     (cq_live[q])
      );

      assign sq_pending[q] = !sq_eq[q];
    end
  endgenerate

  qdb_fetch #(.NQ(NQ), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .fetch_req  (fetch_req),
    .fetch_qid  (fetch_qid),
    .sq_pending (sq_pending),
    .sq_live    (sq_live),
    .sq_head    (sq_head),
    .sq_base    (sq_base),
    .fetch_go   (fetch_go),
    .fetch_ack  (fetch_ack),
    .fetch_addr (fetch_addr)
  );

  qdb_post #(.NQ(NQ), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_post (
    .clk        (clk),
    .rst        (rst),
    .post_req   (post_req),
    .post_sqid  (post_sqid),
    .post_sqe   (post_sqe),
    .bind_tbl   (bind_tbl),
    .cq_full    (cq_full),
    .cq_live    (cq_live),
    .cq_tail    (cq_tail),
    .cq_base    (cq_base),
    .post_go    (post_go),
    .post_cq    (post_cq),
    .post_stall (post_stall),
    .evt_valid  (evt_valid),
    .evt_cqid   (evt_cqid),
    .evt_addr   (evt_addr),
    .evt_sqid   (evt_sqid),
    .evt_sqe    (evt_sqe)
  );
endmodule

// File: rtl/qdb_tracker_chk.sv
module qdb_tracker_chk #(
  parameter int NQ = 4,
  localparam int QW = $clog2(NQ)
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_req,
  input logic [QW-1:0] fetch_qid,
  input logic          fetch_ack,
  input logic          post_req,
  input logic          post_stall,
  input logic          evt_valid,
  input logic [NQ-1:0] sq_pending,
  input logic [NQ-1:0] cq_full,
  input logic [NQ-1:0] cq_empty,
  input logic          err_flag
);
  // R5: a grant needs a request one cycle earlier
  p_ack_cause_r5: assert property (@(posedge clk) disable iff (rst)
    fetch_ack |-> $past(fetch_req));

  // R5: nothing pending means no grant
  p_no_empty_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !sq_pending[fetch_qid]) |=> !fetch_ack);

  // R6: an event always answers a post one cycle earlier
  p_evt_cause_r6: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(post_req));

  // R6: the event lasts one cycle unless a new post arrives
  p_evt_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !post_req) |=> !evt_valid);

  // R7: a refusal and an event never coincide, and a refusal needs a post
  p_stall_excl_r7: assert property (@(posedge clk) disable iff (rst)
    post_stall |-> (!evt_valid && $past(post_req)));

  // R4: the error flag is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R8: a completion ring of size two or more is never full and empty at once
  generate
    for (genvar q = 0; q < NQ; q++) begin : g_cq
      p_full_empty_r8: assert property (@(posedge clk) disable iff (rst)
        !(cq_full[q] && cq_empty[q]));
    end
  endgenerate
endmodule

bind qdb_tracker qdb_tracker_chk #(.NQ(NQ)) u_chk (.*);

// File: tb/qdb_tracker_tb.sv
`timescale 1ns/1ps
module qdb_tracker_tb;
  localparam int NQ = 4, IDX_W = 4, BASE_W = 8, QW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_we = 0, cfg_cq = 0, db_we = 0, db_cq = 0, fetch_req = 0, post_req = 0;
  logic [QW-1:0] cfg_qid = 0, cfg_bind = 0, db_qid = 0, fetch_qid = 0, post_sqid = 0;
  logic [IDX_W:0] cfg_size = 0;
  logic [BASE_W-1:0] cfg_base = 0;
  logic [IDX_W-1:0] db_idx = 0, post_sqe = 0;
  logic fetch_ack, post_stall, evt_valid, err_flag;
  logic [BASE_W+6:0] fetch_addr;
  logic [BASE_W+4:0] evt_addr;
  logic [QW-1:0] evt_cqid, evt_sqid;
  logic [IDX_W-1:0] evt_sqe;
  logic [NQ-1:0] sq_pending, sq_full, cq_full, cq_empty;

  int checks = 0, failures = 0;

  qdb_tracker #(.NQ(NQ), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_dut (.*);

  // kinds
  localparam logic [2:0] K_CSQ = 0, K_CCQ = 1, K_DSQ = 2, K_DCQ = 3, K_FET = 4, K_PST = 5, K_NOP = 6;
  // checks
  localparam logic [2:0] C_NONE = 0, C_FET = 1, C_EVT = 2, C_STL = 3, C_PND = 4, C_CQF = 5, C_CQE = 6;

  // {kind3, q2, a5, b8, c2, chk3, ef1, ev16}
  localparam int NV = 25;
  localparam logic [39:0] TBL [NV] = '{
    {K_CCQ, 2'd1, 5'd4,  8'd16, 2'd0, C_NONE, 1'b0, 16'd0},
    {K_CCQ, 2'd0, 5'd2,  8'd0,  2'd0, C_NONE, 1'b0, 16'd0},
    {K_CSQ, 2'd0, 5'd4,  8'd0,  2'd3, C_NONE, 1'b0, 16'd0},
    {K_CSQ, 2'd1, 5'd8,  8'd32, 2'd1, C_NONE, 1'b0, 16'd0},
    {K_DSQ, 2'd1, 5'd3,  8'd0,  2'd0, C_PND,  1'b1, 16'd0},
    {K_FET, 2'd1, 5'd0,  8'd0,  2'd0, C_FET,  1'b1, 16'd2048},
    {K_FET, 2'd1, 5'd0,  8'd0,  2'd0, C_FET,  1'b1, 16'd2112},
    {K_FET, 2'd1, 5'd0,  8'd0,  2'd0, C_FET,  1'b1, 16'd2176},
    {K_NOP, 2'd1, 5'd0,  8'd0,  2'd0, C_PND,  1'b0, 16'd0},
    {K_FET, 2'd1, 5'd0,  8'd0,  2'd0, C_FET,  1'b0, 16'd0},
    {K_PST, 2'd1, 5'd5,  8'd0,  2'd1, C_EVT,  1'b1, 16'd256},
    {K_PST, 2'd1, 5'd6,  8'd0,  2'd1, C_EVT,  1'b1, 16'd272},
    {K_PST, 2'd1, 5'd7,  8'd0,  2'd1, C_EVT,  1'b1, 16'd288},
    {K_NOP, 2'd1, 5'd0,  8'd0,  2'd0, C_CQF,  1'b1, 16'd0},
    {K_PST, 2'd1, 5'd8,  8'd0,  2'd0, C_STL,  1'b1, 16'd0},
    {K_DCQ, 2'd1, 5'd2,  8'd0,  2'd0, C_CQF,  1'b0, 16'd0},
    {K_PST, 2'd1, 5'd9,  8'd0,  2'd1, C_EVT,  1'b1, 16'd304},
    {K_PST, 2'd1, 5'd10, 8'd0,  2'd1, C_EVT,  1'b1, 16'd256},
    {K_NOP, 2'd1, 5'd0,  8'd0,  2'd0, C_CQF,  1'b1, 16'd0},
    {K_DCQ, 2'd1, 5'd1,  8'd0,  2'd0, C_CQE,  1'b1, 16'd0},
    {K_PST, 2'd0, 5'd1,  8'd0,  2'd0, C_EVT,  1'b1, 16'd0},
    {K_PST, 2'd0, 5'd2,  8'd0,  2'd0, C_STL,  1'b1, 16'd0},
    {K_FET, 2'd0, 5'd0,  8'd0,  2'd0, C_FET,  1'b0, 16'd0},
    {K_DSQ, 2'd0, 5'd2,  8'd0,  2'd0, C_PND,  1'b1, 16'd0},
    {K_FET, 2'd0, 5'd0,  8'd0,  2'd0, C_FET,  1'b1, 16'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] kind, input logic [1:0] q, input logic [4:0] a,
                    input logic [7:0] b, input logic [1:0] c);
    @(negedge clk);
    case (kind)
      K_CSQ, K_CCQ: begin
        cfg_we = 1; cfg_cq = (kind == K_CCQ); cfg_qid = q; cfg_size = a; cfg_base = b; cfg_bind = c;
      end
      K_DSQ, K_DCQ: begin
        db_we = 1; db_cq = (kind == K_DCQ); db_qid = q; db_idx = a[3:0];
      end
      K_FET: begin fetch_req = 1; fetch_qid = q; end
      K_PST: begin post_req = 1; post_sqid = q; post_sqe = a[3:0]; end
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0; db_we = 0; fetch_req = 0; post_req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic reset_state_check();
    check("R1 sq_pending", 32'(sq_pending), 0);
    check("R1 sq_full", 32'(sq_full), 0);
    check("R1 cq_full", 32'(cq_full), 0);
    check("R1 cq_empty", 32'(cq_empty), 32'hF);
    check("R1 err_flag", 32'(err_flag), 0);
    check("R1 strobes", 32'({fetch_ack, evt_valid, post_stall}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    reset_state_check();

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = TBL[i];
      op(v[39:37], v[36:35], v[34:30], v[29:22], v[21:20]);
      case (v[19:17])
        C_FET: begin
          check("R5 fetch_ack", 32'(fetch_ack), 32'(v[16]));
          if (v[16]) check("R5 fetch_addr", 32'(fetch_addr), 32'(v[15:0]));
        end
        C_EVT: begin
          check("R6 evt_valid", 32'(evt_valid), 32'(v[16]));
          check("R6 evt_addr", 32'(evt_addr), 32'(v[15:0]));
          check("R6 R9 evt_cqid", 32'(evt_cqid), 32'(v[21:20]));
          check("R6 evt_sqid", 32'(evt_sqid), 32'(v[36:35]));
          check("R6 evt_sqe", 32'(evt_sqe), 32'(v[33:30]));
          check("R6 no stall", 32'(post_stall), 0);
        end
        C_STL: begin
          check("R7 post_stall", 32'(post_stall), 32'(v[16]));
          check("R7 no event", 32'(evt_valid), 0);
        end
        C_PND: check("R3 sq_pending", 32'(sq_pending[v[36:35]]), 32'(v[16]));
        C_CQF: check("R7 R8 cq_full", 32'(cq_full[v[36:35]]), 32'(v[16]));
        C_CQE: check("R8 cq_empty", 32'(cq_empty[v[36:35]]), 32'(v[16]));
        default: ;
      endcase
    end
    check("R4 no error in table", 32'(err_flag), 0);

    // R1 again after traffic
    do_reset();
    reset_state_check();

    // R4 / R3 / R5 wrap on a size-3 ring
    op(K_CCQ, 2'd1, 5'd4, 8'd0, 2'd0);
    op(K_CSQ, 2'd1, 5'd3, 8'd0, 2'd1);
    op(K_DSQ, 2'd1, 5'd2, 8'd0, 2'd0);
    check("R3 pending after doorbell", 32'(sq_pending[1]), 1);
    check("R3 sq_full at N-1", 32'(sq_full[1]), 1);
    check("R4 in-range doorbell no error", 32'(err_flag), 0);
    op(K_DSQ, 2'd1, 5'd3, 8'd0, 2'd0);
    check("R4 out-of-range sets error", 32'(err_flag), 1);
    op(K_FET, 2'd1, 5'd0, 8'd0, 2'd0);
    check("R5 fetch 0 addr", 32'(fetch_addr), 0);
    op(K_FET, 2'd1, 5'd0, 8'd0, 2'd0);
    check("R5 fetch 1 addr", 32'(fetch_addr), 64);
    op(K_FET, 2'd1, 5'd0, 8'd0, 2'd0);
    check("R4 ignored tail leaves two commands", 32'(fetch_ack), 0);
    op(K_DSQ, 2'd1, 5'd0, 8'd0, 2'd0);
    check("R3 pending after wrap doorbell", 32'(sq_pending[1]), 1);
    op(K_FET, 2'd1, 5'd0, 8'd0, 2'd0);
    check("R5 last slot addr", 32'(fetch_addr), 128);
    check("R5 head wraps to 0", 32'(sq_pending[1]), 0);
    check("R4 error sticky", 32'(err_flag), 1);

    // R10 reconfigure drops contents
    op(K_DSQ, 2'd1, 5'd1, 8'd0, 2'd0);
    check("R10 pending before reconfig", 32'(sq_pending[1]), 1);
    op(K_CSQ, 2'd1, 5'd3, 8'd0, 2'd1);
    check("R10 pending cleared", 32'(sq_pending[1]), 0);

    // R9 I/O ring bound to admin completion ring is refused
    do_reset();
    op(K_CSQ, 2'd2, 5'd4, 8'd0, 2'd0);
    check("R9 refused bind error", 32'(err_flag), 1);
    op(K_DSQ, 2'd2, 5'd1, 8'd0, 2'd0);
    check("R9 refused ring stays unconfigured", 32'(sq_pending[2]), 0);

    // R7 post to an unconfigured completion ring
    do_reset();
    op(K_CSQ, 2'd3, 5'd4, 8'd0, 2'd2);
    op(K_PST, 2'd3, 5'd1, 8'd0, 2'd0);
    check("R7 unconfigured ring stalls", 32'(post_stall), 1);
    check("R7 unconfigured ring no event", 32'(evt_valid), 0);

    // R2 size bounds
    do_reset();
    op(K_CCQ, 2'd3, 5'd17, 8'd0, 2'd0);
    check("R2 size 17 refused", 32'(err_flag), 1);
    do_reset();
    op(K_CCQ, 2'd3, 5'd16, 8'd0, 2'd0);
    check("R2 size 16 accepted", 32'(err_flag), 0);
    op(K_CCQ, 2'd2, 5'd1, 8'd0, 2'd0);
    check("R2 size 1 refused", 32'(err_flag), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule